// File: doc/BRIEF.md
# Bus-Sizing Cycle Controller with Wait States

This block sits on the motherboard side of an expansion bus that carries both 8-bit and 16-bit cards. A host hands it one 16-bit memory or I/O request at a time; the block runs that request on the bus and returns an acknowledge, plus the read word for reads. As soon as a request is accepted, the block drives the upper, unlatched address lines. This lets the addressed card decide early whether it will claim a 16-bit transfer. One clock later the block samples the card's active-low 16-bit-capable response.

If the card claims the cycle and the address is even, a single 16-bit transfer runs on both byte lanes. In every other case the block splits the access into two byte transfers on the low lane. The first goes to the request address and the second to the address plus one, and on a read the two bytes are merged into one word. Each transfer holds its command strobe for a default number of wait clocks. A card can end the strobe early by pulling the active-low zero-wait-state input low. Memory and I/O each have their own read and write strobe.

Top module: `busSizer`

## Requirements
- R1: After reset, all four command strobes are high (inactive), the acknowledge is low and the write data enable is low.
- R2: When the card drives its 16-bit-capable input low in the clock after acceptance and the address is even, exactly one transfer runs, with the wide indicator high, at the request address. Read data is taken from both lanes (bits 15:8 are the odd byte).
- R3: When the card leaves the 16-bit-capable input high, two byte transfers run with the wide indicator low: first at the request address, then at the address plus one. The read word carries the first byte in bits 7:0 and the second byte in bits 15:8, both taken from data bits 7:0.
- R4: A request at an odd address always runs as two byte transfers, even when the card claims 16 bits.
- R5: With the zero-wait-state input held high, a command strobe stays low for 4 clocks in a 16-bit transfer and 6 clocks in each byte transfer.
- R6: The zero-wait-state input is sampled on every clock of a strobe. When it is low at a rising edge, the strobe rises at that edge, so a card that pulls it low after k strobe clocks gets a strobe of k clocks (k below the default).
- R7: Exactly one strobe is active during a transfer: memory read (host I/O flag 0, write flag 0), memory write (0,1), I/O read (1,0) or I/O write (1,1). No strobe is active outside transfers.
- R8: A write drives the whole word in a 16-bit transfer. In a split write, data bits 7:0 carry the low host byte in the first transfer and the high host byte in the second.
- R9: The acknowledge is a single-clock pulse after the last transfer of a request, and the read word is valid while it is high.
- R10: The upper address lines equal address bits 23:17 of the request and do not change while a strobe is active.
- R11: A request pulse that arrives while an earlier request is still running is ignored. It causes no extra transfer and no extra acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Request pulse, accepted only when idle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostIsIo | input | 1 | 1 = I/O space, 0 = memory |
| hostAddr | input | 24 | Byte address of the 16-bit access |
| hostWdata | input | 16 | Write word |
| hostAck | output | 1 | One-clock completion pulse |
| hostRdata | output | 16 | Read word, valid with the acknowledge |
| busLa | output | 7 | Unlatched upper address bits 23:17 |
| busAddr | output | 24 | Latched address of the current transfer |
| busDout | output | 16 | Write data toward the cards |
| busDin | input | 16 | Read data from the cards |
| busDoutEn | output | 1 | Write data is being driven |
| busWide | output | 1 | Current transfer is 16 bits |
| memRdN | output | 1 | Memory read strobe, active low |
| memWrN | output | 1 | Memory write strobe, active low |
| ioRdN | output | 1 | I/O read strobe, active low |
| ioWrN | output | 1 | I/O write strobe, active low |
| card16N | input | 1 | Card claims a 16-bit transfer, active low |
| zeroWsN | input | 1 | Card ends wait states early, active low |

## Verification
The hardest situations to reach from the ports involve timing inside a cycle. One is an early end of the strobe in the second half of a split access. Another is a request pulse that lands while the block is busy. The bench card model counts strobe clocks itself and pulls the zero-wait-state line low after a chosen count in each transfer, so one request can shorten both byte transfers. The driver also raises a second request pulse a few clocks into a running split read. It then checks that the transfer count and the acknowledge count stay as expected.

// File: rtl/busSizerPkg.sv
package busSizerPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_ADDR,
    ST_CMD,
    ST_DONE
  } cycState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // capture a new host request
    logic second;    // second half of a split access
    logic wide;      // current access is one 16-bit transfer
    logic busy;      // address phase or command phase
    logic strobeOn;  // command strobe active
    logic capWide;   // capture full read word
    logic capLo;     // capture low byte of a split read
    logic capHi;     // capture high byte of a split read
  } ctl_t;

endpackage

// File: rtl/busSizerCtl.sv
module busSizerCtl
  import busSizerPkg::*;
#(
  parameter int WS16 = 4,
  parameter int WS8  = 6,
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostReq,
  input  logic card16N,
  input  logic zeroWsN,
  input  logic reqOdd,
  output ctl_t ctl,
  output logic hostAck,
  output logic busWide
);

  cycState_t state;
  logic [CNT_W-1:0] waitCnt;
  logic second;
  logic wide;
  logic endNow;

  assign endNow = (state == ST_CMD) && (!zeroWsN || (waitCnt == CNT_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      second  <= 1'b0;
      wide    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hostReq) begin
            state  <= ST_DECODE;
            second <= 1'b0;
          end
        end
        ST_DECODE: begin
          wide  <= !card16N && !reqOdd;
          state <= ST_ADDR;
        end
        ST_ADDR: begin
          waitCnt <= wide ? CNT_W'(WS16) : CNT_W'(WS8);
          state   <= ST_CMD;
        end
        ST_CMD: begin
          if (endNow) begin
            if (wide || second) begin
              state <= ST_DONE;
            end else begin
              second <= 1'b1;
              state  <= ST_ADDR;
            end
          end else begin
            waitCnt <= waitCnt - CNT_W'(1);
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
          wide  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.loadReq  = (state == ST_IDLE) && hostReq;
    ctl.second   = second;
    ctl.wide     = wide;
    ctl.busy     = (state == ST_ADDR) || (state == ST_CMD);
    ctl.strobeOn = (state == ST_CMD);
    ctl.capWide  = endNow && wide;
    ctl.capLo    = endNow && !wide && !second;
    ctl.capHi    = endNow && !wide && second;
  end

  assign hostAck = (state == ST_DONE);
  assign busWide = wide && ctl.busy;

endmodule

// File: rtl/busSizerDp.sv
module busSizerDp
  import busSizerPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LA_W   = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic              hostWrite,
  input  logic              hostIsIo,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] busDin,
  output logic [DATA_W-1:0] hostRdata,
  output logic [LA_W-1:0]   busLa,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoutEn,
  output logic              reqOdd,
  output logic [3:0]        strobeN
);

  localparam int BYTE_W = DATA_W / 2;

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [DATA_W-1:0] rdata;
  logic              reqWrite;
  logic              reqIo;
  logic [BYTE_W-1:0] byteOut;
  logic [3:0]        kindHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWdata <= '0;
      reqWrite <= 1'b0;
      reqIo    <= 1'b0;
      rdata    <= '0;
    end else begin
      if (ctl.loadReq) begin
        reqAddr  <= hostAddr;
        reqWdata <= hostWdata;
        reqWrite <= hostWrite;
        reqIo    <= hostIsIo;
      end
      if (ctl.capWide) rdata <= busDin;
      if (ctl.capLo)   rdata[BYTE_W-1:0] <= busDin[BYTE_W-1:0];
      if (ctl.capHi)   rdata[DATA_W-1:BYTE_W] <= busDin[BYTE_W-1:0];
    end
  end

  assign busLa     = reqAddr[ADDR_W-1 -: LA_W];
  assign busAddr   = reqAddr + ADDR_W'(ctl.second);
  assign reqOdd    = reqAddr[0];
  assign hostRdata = rdata;
  assign byteOut   = ctl.second ? reqWdata[DATA_W-1:BYTE_W] : reqWdata[BYTE_W-1:0];
  assign busDout   = ctl.wide ? reqWdata : {{BYTE_W{1'b0}}, byteOut};
  assign busDoutEn = reqWrite && ctl.busy;

  // strobe index: {io, write} -> 0 memRd, 1 memWr, 2 ioRd, 3 ioWr
  for (genvar k = 0; k < 4; k++) begin : g_strobe
    assign kindHit[k] = ({reqIo, reqWrite} == 2'(k));
    assign strobeN[k] = !(ctl.strobeOn && kindHit[k]);
  end

endmodule

// File: rtl/busSizer.sv
module busSizer
  import busSizerPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LA_W   = 7,
  parameter int DATA_W = 16,
  parameter int WS16   = 4,
  parameter int WS8    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostIsIo,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic [LA_W-1:0]   busLa,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  input  logic [DATA_W-1:0] busDin,
  output logic              busDoutEn,
  output logic              busWide,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  input  logic              card16N,
  input  logic              zeroWsN
);

  localparam int WS_MAX = (WS16 > WS8) ? WS16 : WS8;
  localparam int CNT_W  = $clog2(WS_MAX + 1);

  ctl_t       ctl;
  logic       reqOdd;
  logic [3:0] strobeN;

  busSizerCtl #(.WS16(WS16), .WS8(WS8), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .card16N(card16N),
    .zeroWsN(zeroWsN), .reqOdd(reqOdd), .ctl(ctl), .hostAck(hostAck),
    .busWide(busWide)
  );

  busSizerDp #(.ADDR_W(ADDR_W), .LA_W(LA_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostWrite(hostWrite),
    .hostIsIo(hostIsIo), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .busDin(busDin), .hostRdata(hostRdata), .busLa(busLa),
    .busAddr(busAddr), .busDout(busDout), .busDoutEn(busDoutEn),
    .reqOdd(reqOdd), .strobeN(strobeN)
  );

  assign memRdN = strobeN[0];
  assign memWrN = strobeN[1];
  assign ioRdN  = strobeN[2];
  assign ioWrN  = strobeN[3];

endmodule

// File: rtl/busSizerChk.sv
module busSizerChk #(
  parameter int ADDR_W = 24,
  parameter int LA_W   = 7,
  parameter int WS_MAX = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostAck,
  input logic [LA_W-1:0]   busLa,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWide,
  input logic              memRdN,
  input logic              memWrN,
  input logic              ioRdN,
  input logic              ioWrN,
  input logic              zeroWsN
);

  logic [3:0] actV;
  logic       anyStb;
  logic [7:0] stbRun;

  assign actV   = ~{memRdN, memWrN, ioRdN, ioWrN};
  assign anyStb = |actV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbRun <= '0;
    else if (anyStb) stbRun <= stbRun + 8'd1;
    else stbRun <= '0;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN) $countones(actV) <= 1); // R7
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN) hostAck |=> !hostAck); // R9
  AST_LA_STABLE: assert property (@(posedge clk) disable iff (!rstN) (anyStb && $past(anyStb)) |-> $stable(busLa)); // R10
  AST_WIDE_EVEN: assert property (@(posedge clk) disable iff (!rstN) (anyStb && busWide) |-> !busAddr[0]); // R4
  AST_STROBE_MAX: assert property (@(posedge clk) disable iff (!rstN) anyStb |-> (stbRun < 8'(WS_MAX))); // R5
  AST_ZWS_END: assert property (@(posedge clk) disable iff (!rstN) (anyStb && !zeroWsN) |=> !anyStb); // R6

endmodule

bind busSizer busSizerChk #(.ADDR_W(ADDR_W), .LA_W(LA_W), .WS_MAX(WS_MAX)) u_chk (
  .clk(clk), .rstN(rstN), .hostAck(hostAck), .busLa(busLa), .busAddr(busAddr),
  .busWide(busWide), .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN),
  .ioWrN(ioWrN), .zeroWsN(zeroWsN)
);

// File: tb/busSizer_tb.sv
module busSizer_tb;

  localparam int CLK_NS = 20;
  localparam logic [6:0] WIDE_LA = 7'h05;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWrite = 1'b0, hostIsIo = 1'b0;
  logic [23:0] hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic        hostAck;
  logic [15:0] hostRdata;
  logic [6:0]  busLa;
  logic [23:0] busAddr;
  logic [15:0] busDout, busDin;
  logic        busDoutEn, busWide;
  logic        memRdN, memWrN, ioRdN, ioWrN;
  logic        card16N;
  logic        zeroWsN = 1'b1;

  int errors = 0, checks = 0;

  always #(CLK_NS/2) clk = ~clk;

  busSizer u_dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostIsIo(hostIsIo), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostAck(hostAck), .hostRdata(hostRdata), .busLa(busLa), .busAddr(busAddr),
    .busDout(busDout), .busDin(busDin), .busDoutEn(busDoutEn), .busWide(busWide),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .card16N(card16N), .zeroWsN(zeroWsN)
  );

  // card model
  logic [7:0] mem [0:255];
  logic [7:0] refMem [0:255];
  logic [7:0] ca;
  assign ca      = busAddr[7:0];
  assign card16N = !(busLa == WIDE_LA);
  assign busDin  = busWide ? {mem[ca + 8'd1], mem[ca]} : {8'hEE, mem[ca]};

  // monitor state
  int          zwsK = 0;
  int          curLen = 0, subCount = 0, ackCount = 0;
  int          lenLog [0:3];
  logic [23:0] addrLog [0:3];
  logic        wideLog [0:3];
  logic [3:0]  maskSeen = '0;
  logic        prevAct = 1'b0, laBad = 1'b0, curRead = 1'b0;
  logic [6:0]  laHold = '0;
  logic [15:0] expQ [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] actV;
    actV = ~{memRdN, memWrN, ioRdN, ioWrN};
    if (|actV) begin
      curLen++;
      maskSeen |= actV;
      if (curLen == 1) begin
        if (subCount < 4) begin
          addrLog[subCount] = busAddr;
          wideLog[subCount] = busWide;
        end
        laHold = busLa;
      end else if (busLa != laHold) laBad = 1'b1;
      if (!memWrN || !ioWrN) begin
        mem[ca] = busDout[7:0];
        if (busWide) mem[ca + 8'd1] = busDout[15:8];
      end
      zeroWsN = !(zwsK != 0 && curLen >= zwsK);
    end else begin
      if (prevAct) begin
        if (subCount < 4) lenLog[subCount] = curLen;
        subCount++;
      end
      curLen = 0;
      zeroWsN = 1'b1;
    end
    prevAct = |actV;
    if (hostAck) begin
      ackCount++;
      if (curRead) begin
        if (expQ.size() == 0) check(1'b0, "R9", "unexpected read ack", hostRdata, 0);
        else begin
          logic [15:0] e;
          e = expQ.pop_front();
          check(hostRdata == e, "R9", "read word", hostRdata, e);
        end
      end
    end
  end

  task automatic runTxn(input bit wr, input bit io, input logic [23:0] addr,
                        input logic [15:0] wd, input int zk, input int expSubs,
                        input int expLen, input int poke, input string tag);
    logic [7:0] a;
    int acks0, n;
    logic [3:0] expMask;
    a = addr[7:0];
    expMask = 4'b0001 << {io, wr};
    expMask = {expMask[0], expMask[1], expMask[2], expMask[3]};
    if (!wr) expQ.push_back({refMem[a + 8'd1], refMem[a]});
    acks0 = ackCount;
    @(negedge clk);
    subCount = 0; maskSeen = '0; laBad = 1'b0; zwsK = zk; curRead = !wr;
    hostReq = 1'b1; hostWrite = wr; hostIsIo = io; hostAddr = addr; hostWdata = wd;
    @(negedge clk);
    hostReq = 1'b0;
    n = 0;
    while (ackCount == acks0 && n < 300) begin
      @(negedge clk);
      n++;
      if (poke != 0 && n == poke) begin
        hostReq = 1'b1; hostAddr = addr ^ 24'h40;
      end else hostReq = 1'b0;
    end
    check(n < 300, tag, "ack timeout", n, 0);
    repeat (4) @(negedge clk);
    check(ackCount == acks0 + 1, tag, "ack count", ackCount - acks0, 1);
    check(subCount == expSubs, tag, "transfer count", subCount, expSubs);
    check(lenLog[0] == expLen, tag, "strobe clocks", lenLog[0], expLen);
    if (expSubs == 2) check(lenLog[1] == expLen, tag, "second strobe clocks", lenLog[1], expLen);
    check(addrLog[0] == addr, tag, "first address", addrLog[0], addr);
    if (expSubs == 2) check(addrLog[1] == addr + 24'd1, tag, "second address", addrLog[1], addr + 24'd1);
    check(wideLog[0] == (expSubs == 1), tag, "wide flag", wideLog[0], expSubs == 1);
    check(maskSeen == expMask, "R7", "strobe line", maskSeen, expMask);
    check(!laBad, "R10", "upper lines moved", laBad, 0);
    check(busLa == addr[23:17], "R10", "upper lines value", busLa, addr[23:17]);
    if (wr) begin
      refMem[a] = wd[7:0];
      refMem[a + 8'd1] = wd[15:8];
      check({mem[a + 8'd1], mem[a]} == wd, "R8", "card bytes", {mem[a + 8'd1], mem[a]}, wd);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      refMem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check({memRdN, memWrN, ioRdN, ioWrN} == 4'hF, "R1", "strobes", {memRdN, memWrN, ioRdN, ioWrN}, 4'hF);
    check(!hostAck && !busDoutEn, "R1", "ack/enable", {hostAck, busDoutEn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runTxn(1'b0, 1'b0, 24'h0A0010, 16'h0, 0, 1, 4, 0, "R2");  // R5 wide default
    runTxn(1'b0, 1'b0, 24'h020020, 16'h0, 0, 2, 6, 0, "R3");  // R5 byte default
    runTxn(1'b0, 1'b0, 24'h0A0031, 16'h0, 0, 2, 6, 0, "R4");
    runTxn(1'b1, 1'b0, 24'h0A0040, 16'hBEEF, 0, 1, 4, 0, "R8");
    runTxn(1'b1, 1'b1, 24'h020050, 16'h1234, 0, 2, 6, 0, "R8");
    runTxn(1'b0, 1'b1, 24'h020050, 16'h0, 2, 2, 2, 0, "R6");
    runTxn(1'b0, 1'b0, 24'h0A0060, 16'h0, 1, 1, 1, 0, "R6");
    runTxn(1'b0, 1'b0, 24'h020070, 16'h0, 0, 2, 6, 3, "R11");
    runTxn(1'b0, 1'b1, 24'h0A0040, 16'h0, 0, 1, 4, 0, "R7");
    runTxn(1'b1, 1'b0, 24'h0A0083, 16'hA55A, 3, 2, 3, 0, "R4");
    check(expQ.size() == 0, "R9", "pending reads", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule